// File: doc/BRIEF.md
# Successive-Approximation ADC Control Unit

This block is the digital side of a successive-approximation analog-to-digital converter in a microcontroller. Software reaches it through a byte-wide register bus with four locations: a mode register, a control/status register, and a result that is split over a high byte and a low byte. Toward the analog side the block drives a 4-bit input select and a 10-bit trial code for the DAC. It takes back one comparator bit, which is high when the selected input is at or above the trial code.

Software picks an input and sets the start bit. The unit takes one sample cycle and then resolves ten bits, most significant bit first. On the same clock edge it stores the result, clears the busy/start bit and sets the end-of-conversion flag. The flag drives the interrupt line only while the interrupt enable bit is set.

A freeze input models the low-power operating modes. While it is high, every register holds its value and a running conversion pauses. A synchronous reset clears the mode and control registers. It does not clear the result bytes.

Top module: `adc_ctl_unit`

## Requirements
- R1: After reset the mode register reads 0x00, the control register reads 0x00, `irq` is 0 and `dac_code` is 0.
- R2: Writing address 1 with bit 7 set while idle starts a conversion. Bit 7 of address 1 reads 1 until the 11th rising edge after the write edge, where it clears. A start write made while a conversion runs has no effect and does not restart it.
- R3: The trial sequence sets bits from 9 down to 0. A bit is kept when the comparator reports the selected input at or above the trial code, so the final result equals the selected 10-bit input level.
- R4: Address 2 reads result bits 9:2. Address 3 reads result bits 1:0 in its bits 7:6, and its bits 5:0 read 0.
- R5: On the edge where busy clears, the result bytes update and the flag (bit 5 of address 1) sets.
- R6: `irq` equals flag AND enable (bit 6 of address 1) with one cycle of delay. With the enable at 0, the flag still sets but `irq` stays 0.
- R7: The flag clears only when address 1 is written with bit 5 at 0, and writing bit 5 as 1 leaves it unchanged. When a completion and a clearing write fall on the same edge, the flag ends up set.
- R8: Writing address 1 with bit 7 at 0 during a conversion aborts it. The flag stays clear and the result bytes keep their old value.
- R9: `adc_chan` follows mode register bits 3:0, and bits 7:4 are stored and read back. Writes to address 0 are ignored while a conversion runs.
- R10: While `lp_freeze` is 1, no register changes and bus writes are ignored. A running conversion resumes where it stopped, so its completion is delayed by exactly the number of frozen cycles.
- R11: Reset leaves the result bytes unchanged.
- R12: Starting again after a completed conversion runs a new conversion with the same completion sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_freeze | input | 1 | Low-power hold: all state frozen |
| bus_addr | input | 2 | Register address: 0 mode, 1 control, 2 result high, 3 result low |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered one cycle after the address |
| adc_chan | output | 4 | Analog input select |
| dac_code | output | 10 | Trial code to the DAC |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| irq | output | 1 | End-of-conversion interrupt request |

## Verification
The bench measures completion to the exact cycle, both with and without a freeze window in the middle of a conversion. A design that kept counting while frozen, or that added a stage, would show busy on the wrong read. It also lands a flag-clearing write on the completion edge, which catches a design that gives software priority and loses the event. Other directed cases cover an abort with no flag set, a restart request while busy, a channel change while busy, and a reset between conversions. Each of these exposes a design that restarts, switches input mid-conversion, or wipes the result. The input levels include the all-zeros code, the all-ones code, the values on either side of half scale and alternating bit patterns, so a wrong keep rule or a wrong bit order shows up in the result bytes.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  typedef enum logic [1:0] {
    ADR_MODE = 2'd0,
    ADR_CTRL = 2'd1,
    ADR_RHI  = 2'd2,
    ADR_RLO  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SAMPLE = 2'd1,
    SEQ_TRIAL  = 2'd2
  } seq_state_e;

  // control register bit positions (software decodes these)
  localparam int CTL_START = 7;
  localparam int CTL_IEN   = 6;
  localparam int CTL_FLAG  = 5;

endpackage

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_ctl_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                freeze,
  input  logic                start,
  input  logic                abort,
  input  logic                cmp,
  output logic                busy,
  output logic                finish,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] conv_result
);

  localparam int IDX_W = $clog2(RES_BITS);
  localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

  seq_state_e          state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [RES_BITS-1:0] code_q;
  logic [RES_BITS-1:0] trial_mask;
  logic [RES_BITS-1:0] kept;

  // trial bit survives when the input is at or above the trial code
  always_comb begin
    trial_mask = RES_BITS'(1) << idx_q;
    kept       = cmp ? code_q : (code_q & ~trial_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      code_q  <= '0;
    end else if (!freeze) begin
      if (abort && state_q != SEQ_IDLE) begin
        state_q <= SEQ_IDLE;
        idx_q   <= '0;
        code_q  <= '0;
      end else begin
        case (state_q)
          SEQ_IDLE: begin
            if (start) state_q <= SEQ_SAMPLE;
          end
          SEQ_SAMPLE: begin
            state_q <= SEQ_TRIAL;
            idx_q   <= IDX_W'(RES_BITS - 1);
            code_q  <= TOP_BIT;
          end
          SEQ_TRIAL: begin
            if (idx_q == '0) begin
              state_q <= SEQ_IDLE;
              code_q  <= '0;
            end else begin
              code_q <= kept | (trial_mask >> 1);
              idx_q  <= idx_q - 1'b1;
            end
          end
          default: state_q <= SEQ_IDLE;
        endcase
      end
    end
  end

  assign busy        = (state_q != SEQ_IDLE);
  assign finish      = (state_q == SEQ_TRIAL) && (idx_q == '0) && !freeze && !abort;
  assign dac_code    = code_q;
  assign conv_result = kept;

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(freeze)) |-> ($stable(code_q) && $stable(state_q))) // R10
    else $error("AST_FREEZE_HOLD");

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (abort && !freeze) |=> !busy) // R8
    else $error("AST_ABORT_IDLE");

  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_SAMPLE && !freeze && !abort) |=> (dac_code == TOP_BIT)) // R3
    else $error("AST_MSB_FIRST");

endmodule

// File: rtl/adc_regs.sv
module adc_regs
  import adc_ctl_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int DATA_W   = 8,
  parameter int CH_BITS  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                freeze,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                busy,
  input  logic                finish,
  input  logic [RES_BITS-1:0] conv_result,
  output logic [DATA_W-1:0]   rdata,
  output logic [CH_BITS-1:0]  chan,
  output logic                start_req,
  output logic                abort_req,
  output logic                irq
);

  localparam int LO_BITS = RES_BITS - DATA_W;

  logic [DATA_W-1:0]   mode_q;
  logic                ien_q;
  logic                flag_q;
  logic [RES_BITS-1:0] res_q;
  logic [DATA_W-1:0]   rdata_q;
  logic                irq_q;
  logic                wr_mode, wr_ctrl;
  logic [DATA_W-1:0]   rd_mux;

  always_comb begin
    wr_mode   = wr_en && !freeze && (addr == ADR_MODE);
    wr_ctrl   = wr_en && !freeze && (addr == ADR_CTRL);
    start_req = wr_ctrl && wdata[CTL_START] && !busy;
    abort_req = wr_ctrl && !wdata[CTL_START] && busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_mode && !busy) mode_q <= wdata;
      if (wr_ctrl) ien_q <= wdata[CTL_IEN];
      if (finish) flag_q <= 1'b1;
      else if (wr_ctrl && !wdata[CTL_FLAG]) flag_q <= 1'b0;
    end
  end

  // result survives reset on purpose
  always_ff @(posedge clk) begin
    if (finish) res_q <= conv_result;
  end

  always_comb begin
    case (addr)
      ADR_MODE: rd_mux = mode_q;
      ADR_CTRL: begin
        rd_mux            = '0;
        rd_mux[CTL_START] = busy;
        rd_mux[CTL_IEN]   = ien_q;
        rd_mux[CTL_FLAG]  = flag_q;
      end
      ADR_RHI:  rd_mux = res_q[RES_BITS-1 -: DATA_W];
      default:  rd_mux = {res_q[LO_BITS-1:0], {(DATA_W-LO_BITS){1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else if (!freeze) begin
      rdata_q <= rd_mux;
      irq_q   <= flag_q & ien_q;
    end
  end

  assign rdata = rdata_q;
  assign chan  = mode_q[CH_BITS-1:0];
  assign irq   = irq_q;

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    finish |=> flag_q) // R5
    else $error("AST_FLAG_ON_DONE");

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ien_q)) |-> !irq) // R6
    else $error("AST_IRQ_NEEDS_EN");

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flag_q) && !$past(wr_ctrl && !wdata[CTL_FLAG])) |-> flag_q) // R7
    else $error("AST_FLAG_STICKY");

  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(busy)) |-> $stable(chan)) // R9
    else $error("AST_CHAN_HELD");

endmodule

// File: rtl/adc_ctl_unit.sv
module adc_ctl_unit
  import adc_ctl_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int DATA_W   = 8,
  parameter int CH_BITS  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lp_freeze,
  input  logic [1:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [CH_BITS-1:0]  adc_chan,
  output logic [RES_BITS-1:0] dac_code,
  input  logic                cmp_in,
  output logic                irq
);

  logic                busy, finish, start_req, abort_req;
  logic [RES_BITS-1:0] conv_result;

  adc_regs #(
    .RES_BITS (RES_BITS),
    .DATA_W   (DATA_W),
    .CH_BITS  (CH_BITS)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .freeze      (lp_freeze),
    .wr_en       (bus_wr),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .busy        (busy),
    .finish      (finish),
    .conv_result (conv_result),
    .rdata       (bus_rdata),
    .chan        (adc_chan),
    .start_req   (start_req),
    .abort_req   (abort_req),
    .irq         (irq)
  );

  adc_sar_seq #(
    .RES_BITS (RES_BITS)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .freeze      (lp_freeze),
    .start       (start_req),
    .abort       (abort_req),
    .cmp         (cmp_in),
    .busy        (busy),
    .finish      (finish),
    .dac_code    (dac_code),
    .conv_result (conv_result)
  );

  AST_DAC_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(busy) && !$past(start_req)) |-> (dac_code == '0)) // R1
    else $error("AST_DAC_IDLE_ZERO");

endmodule

// File: tb/adc_ctl_unit_test.sv
`timescale 1ns/1ps
module adc_ctl_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lp_freeze = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] adc_chan;
  logic [9:0] dac_code;
  logic       cmp_in;
  logic       irq;
  logic [9:0] vin_arr [16];

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  assign cmp_in = (vin_arr[adc_chan] >= dac_code);

  adc_ctl_unit uut (
    .clk(clk), .rst(rst), .lp_freeze(lp_freeze), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .adc_chan(adc_chan), .dac_code(dac_code), .cmp_in(cmp_in), .irq(irq)
  );

  // {channel, input level}
  localparam logic [13:0] VEC [7] = '{
    {4'h5, 10'd0}, {4'h5, 10'd1023}, {4'h2, 10'd512}, {4'hA, 10'd511},
    {4'h0, 10'h2AA}, {4'hF, 10'h155}, {4'h7, 10'd3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // tasks start and end on a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    logic [9:0] last_res;
    logic [9:0] dsnap;
    for (int i = 0; i < 16; i++) vin_arr[i] = 10'(i * 37);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, rv); chk("R1 mode", rv, 8'h00);
    rd(2'd1, rv); chk("R1 ctrl", rv, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 dac", dac_code, 0);

    // vector walk; later entries also cover restart R12
    for (int v = 0; v < 7; v++) begin
      logic [3:0] ch;
      logic [9:0] lvl;
      ch = VEC[v][13:10]; lvl = VEC[v][9:0];
      for (int i = 0; i < 16; i++) vin_arr[i] = ~lvl;
      vin_arr[ch] = lvl;
      wr(2'd0, {4'h0, ch});
      wr(2'd1, 8'hC0);
      repeat (10) @(negedge clk);
      rd(2'd1, rv); chk("R2 busy before last edge", rv, 8'hC0);
      rd(2'd1, rv); chk("R5 done flag R12", rv, 8'h60);
      chk("R6 irq enabled", irq, 1);
      chk("R9 chan out", adc_chan, ch);
      rd(2'd2, rv); chk("R3 R4 hi", rv, lvl[9:2]);
      rd(2'd3, rv); chk("R4 lo", rv, {lvl[1:0], 6'b0});
      last_res = lvl;
    end

    // R8 abort
    vin_arr[adc_chan] = 10'd100;
    wr(2'd1, 8'hC0);
    repeat (3) @(negedge clk);
    wr(2'd1, 8'h40);
    repeat (15) @(negedge clk);
    rd(2'd1, rv); chk("R8 abort ctrl", rv, 8'h40);
    rd(2'd2, rv); chk("R8 result kept hi", rv, last_res[9:2]);
    chk("R8 irq", irq, 0);

    // R2 start while busy ignored, R9 mode write while busy ignored
    vin_arr[5] = 10'd777;
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'hC0);
    wr(2'd0, 8'h03);
    wr(2'd1, 8'hC0);
    repeat (8) @(negedge clk);
    rd(2'd1, rv); chk("R2 restart ignored busy", rv, 8'hC0);
    rd(2'd1, rv); chk("R2 restart ignored done", rv, 8'h60);
    rd(2'd0, rv); chk("R9 mode held", rv, 8'hA5);
    rd(2'd2, rv); chk("R3 ch5 hi", rv, 8'(10'd777 >> 2));
    last_res = 10'd777;

    // R7 clear lands on completion edge
    vin_arr[5] = 10'd200;
    wr(2'd1, 8'hC0);
    repeat (10) @(negedge clk);
    wr(2'd1, 8'hC0);
    rd(2'd1, rv); chk("R7 completion beats clear", rv, 8'h60);
    wr(2'd1, 8'h60);
    rd(2'd1, rv); chk("R7 write one no effect", rv, 8'h60);
    wr(2'd1, 8'h40);
    rd(2'd1, rv); chk("R7 write zero clears", rv, 8'h40);
    chk("R7 irq drops", irq, 0);
    last_res = 10'd200;

    // R6 enable off
    vin_arr[5] = 10'd300;
    wr(2'd1, 8'h80);
    repeat (14) @(negedge clk);
    rd(2'd1, rv); chk("R6 flag without enable", rv, 8'h20);
    chk("R6 irq masked", irq, 0);
    last_res = 10'd300;

    // R10 freeze mid-conversion, abort write ignored while frozen
    vin_arr[5] = 10'd613;
    wr(2'd1, 8'hC0);
    repeat (3) @(negedge clk);
    lp_freeze = 1'b1;
    dsnap = dac_code;
    wr(2'd1, 8'h40);
    repeat (5) @(negedge clk);
    chk("R10 dac frozen", dac_code, dsnap);
    lp_freeze = 1'b0;
    repeat (7) @(negedge clk);
    rd(2'd1, rv); chk("R10 delayed busy", rv, 8'hC0);
    rd(2'd1, rv); chk("R10 delayed done", rv, 8'h60);
    rd(2'd2, rv); chk("R10 hi", rv, 8'(10'd613 >> 2));
    rd(2'd3, rv); chk("R10 lo", rv, {2'b01, 6'b0});
    last_res = 10'd613;

    // R10 idle write ignored while frozen
    lp_freeze = 1'b1;
    wr(2'd0, 8'h07);
    lp_freeze = 1'b0;
    rd(2'd0, rv); chk("R10 mode write frozen", rv, 8'hA5);

    // R11 result survives reset
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(2'd2, rv); chk("R11 hi kept", rv, last_res[9:2]);
    rd(2'd3, rv); chk("R11 lo kept", rv, {last_res[1:0], 6'b0});
    rd(2'd0, rv); chk("R1 mode after reset", rv, 8'h00);
    rd(2'd1, rv); chk("R1 ctrl after reset", rv, 8'h00);
    chk("R1 irq after reset", irq, 0);

    finish_run();
  end

endmodule